// File: doc/BRIEF.md
# Anticipatory RNS Modular Adder

This block adds two residues of a fixed modulus `m` and returns `(A + B) mod m`. Both operands are assumed to be already reduced, so the true sum lies between 0 and `2m - 2`. A single subtraction of `m` is therefore enough to bring it back into range. The block does not compare first and then subtract. It builds two candidates in the same cycle: the plain sum `A + B` and the reduced sum `A + B - m`. It then keeps the reduced one exactly when that one is not negative.

Each candidate has its own Kogge-Stone parallel prefix carry network. The reduced candidate takes `A`, `B` and the two's complement of `m` directly. The constant is folded into the bitwise generate/propagate cells, so no carry-save row sits in front of the prefix tree. The modulus comes from a compile-time selector over three moduli close to `2^N`. A parameter can place a register on the result, which gives one clock of latency. The block is meant as one lane of a residue-number datapath, for example inside filter accumulators.

Top module: `rns_modadd_anticip`

## Requirements
- R1: When the operands are residues and `A + B < m`, the result equals `A + B`.
- R2: When the operands are residues and `A + B >= m`, the result equals `A + B - m`. The choice follows the sign of the reduced candidate, which is computed two bits wider than `N`.
- R3: `MOD_KIND` selects the modulus:
  - 0 selects `2^N - 2^(N-2) - 1`, which is 49151 for N = 16.
  - 1 selects `2^N - 2^(N-2)`, which is 49152.
  - 2 selects `2^N - 2^(N-3) - 1`, which is 57343.
- R4: For residue operands the result is always in the range 0 to `m - 1`.
- R5: The boundary sums map as follows: `m - 1` gives `m - 1`, `m` gives 0, `m + 1` gives 1, and `2m - 2` gives `m - 2`.
- R6: Zero operands pass through: `0 + 0` gives 0, and `x + 0` or `0 + x` gives `x`.
- R7: Output timing depends on `REG_OUT`.
  - With `REG_OUT = 0`, the result follows the operands in the same cycle.
  - With `REG_OUT = 1`, the result of the operands present at a rising clock edge appears after that edge. It holds until the next edge.
- R8: With `REG_OUT = 1`, driving `rst_n` low clears the result to 0 at once, without waiting for a clock edge. The result stays 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional result register |
| rst_n | input | 1 | Asynchronous active-low reset of the result register |
| opa | input | N | First residue operand, below m |
| opb | input | N | Second residue operand, below m |
| res | output | N | Modular sum (A + B) mod m |

## Verification
The plain-sum path and the reduced-sum path are evaluated together in every cycle, and the selection decides which one reaches the port. The bench forces that decision to its edge by driving sums of exactly `m - 1`, `m`, `m + 1` and `2m - 2` for every modulus, with the operands in both orders. These directed cases sit among random residue pairs. Every result is compared with `(A + B) % m` computed in the bench.

On the registered variant, capturing a new sum can fall in the same cycle as holding the previous one. The bench changes the operands half a cycle before an edge and confirms that the old value is still present. After the edge it confirms the new value. It also pulls reset low between edges and expects zero before any clock arrives.

// File: rtl/rma_pkg.sv
package rma_pkg;

  localparam int unsigned RMA_KIND_COUNT = 3;

  // Modulus family, selected by kind.
  //   kind 0 : 2^n - 2^(n-2) - 1
  //   kind 1 : 2^n - 2^(n-2)
  //   kind 2 : 2^n - 2^(n-3) - 1
  function automatic int unsigned rma_modulus(input int unsigned n, input int unsigned kind);
    int unsigned top;
    top = 32'd1 << n;
    case (kind)
      0:       return top - ((32'd1 << (n - 2)) + 32'd1);
      1:       return top - (32'd1 << (n - 2));
      default: return top - ((32'd1 << (n - 3)) + 32'd1);
    endcase
  endfunction

endpackage

// File: rtl/rma_leaf_pair.sv
// Bitwise generate/propagate for the plain two-operand sum.
// Operands are zero-extended to W bits so the carry out of bit N-1 survives.
module rma_leaf_pair #(
  parameter int N = 16,
  parameter int W = N + 1
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [W-1:0] g,
  output logic [W-1:0] p
);

  logic [W-1:0] ae;
  logic [W-1:0] be;

  assign ae = {{(W-N){1'b0}}, a};
  assign be = {{(W-N){1'b0}}, b};

  assign g = ae & be;
  assign p = ae ^ be;

endmodule

// File: rtl/rma_leaf_const3.sv
// Three-input leaf: A + B + K, where K is a constant bit pattern.
// Each bit of K picks its own gate form at elaboration, so the constant
// disappears into the leaf cells and no compression row is needed.
// Bit i yields a half-sum h[i] and a carry c[i] into bit i+1. The pair
// (h, c<<1) then feeds the prefix network as an ordinary two-term sum.
module rma_leaf_const3 #(
  parameter int            N = 16,
  parameter int            W = N + 2,
  parameter logic [W-1:0]  K = '0
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [W-1:0] g,
  output logic [W-1:0] p
);

  logic [W-1:0] ae;
  logic [W-1:0] be;
  logic [W-1:0] h;
  logic [W-2:0] c;
  logic [W-1:0] cs;

  assign ae = {{(W-N){1'b0}}, a};
  assign be = {{(W-N){1'b0}}, b};

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (K[i]) begin : g_one
      // a + b + 1 : half-sum inverts, carry when either input is set
      assign h[i] = ~(ae[i] ^ be[i]);
      if (i < W - 1) begin : g_cy
        assign c[i] = ae[i] | be[i];
      end
    end else begin : g_zero
      // a + b + 0 : ordinary half adder
      assign h[i] = ae[i] ^ be[i];
      if (i < W - 1) begin : g_cy
        assign c[i] = ae[i] & be[i];
      end
    end
  end

  assign cs = {c, 1'b0};
  assign g  = h & cs;
  assign p  = h ^ cs;

endmodule

// File: rtl/rma_ks_prefix.sv
// Kogge-Stone carry network with a zero carry-in.
// sum[W] is the carry out of the top bit.
module rma_ks_prefix #(
  parameter int W = 17
) (
  input  logic [W-1:0] g_in,
  input  logic [W-1:0] p_in,
  output logic [W:0]   sum
);

  localparam int LEVELS = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0] carry;

  always_comb begin
    logic [W-1:0] gv;
    logic [W-1:0] pv;
    logic [W-1:0] gn;
    logic [W-1:0] pn;
    gv = g_in;
    pv = p_in;
    for (int l = 0; l < LEVELS; l++) begin
      gn = gv;
      pn = pv;
      for (int i = 0; i < W; i++) begin
        if (i >= (1 << l)) begin
          gn[i] = gv[i] | (pv[i] & gv[i - (1 << l)]);
          pn[i] = pv[i] & pv[i - (1 << l)];
        end
      end
      gv = gn;
      pv = pn;
    end
    carry = gv;
  end

  if (W > 1) begin : g_wide
    assign sum = {carry[W-1], p_in ^ {carry[W-2:0], 1'b0}};
  end else begin : g_narrow
    assign sum = {carry[0], p_in};
  end

endmodule

// File: rtl/rns_modadd_anticip.sv
module rns_modadd_anticip
  import rma_pkg::*;
#(
  parameter int N        = 16,
  parameter int MOD_KIND = 0,
  parameter bit REG_OUT  = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] opa,
  input  logic [N-1:0] opb,
  output logic [N-1:0] res
);

  localparam int unsigned  MODULUS = rma_modulus(N, MOD_KIND);
  localparam int           W_PL    = N + 1;            // plain-sum width
  localparam int           W_RD    = N + 2;            // reduced-sum width
  localparam logic [N:0]   MOD_V   = (N+1)'(MODULUS);
  // Two's complement of m at N+1 bits, zero-extended to W_RD.
  localparam logic [W_RD-1:0] NEG_M = W_RD'((32'd1 << (N + 1)) - MODULUS);

  // ---------------- plain path: A + B ----------------
  logic [W_PL-1:0] pl_g;
  logic [W_PL-1:0] pl_p;
  logic [W_PL:0]   pl_sum;

  rma_leaf_pair #(.N(N), .W(W_PL)) u_leaf_pl (
    .a (opa),
    .b (opb),
    .g (pl_g),
    .p (pl_p)
  );

  rma_ks_prefix #(.W(W_PL)) u_ks_pl (
    .g_in (pl_g),
    .p_in (pl_p),
    .sum  (pl_sum)
  );

  // ---------------- reduced path: A + B - m ----------------
  logic [W_RD-1:0] rd_g;
  logic [W_RD-1:0] rd_p;
  logic [W_RD:0]   rd_sum;

  rma_leaf_const3 #(.N(N), .W(W_RD), .K(NEG_M)) u_leaf_rd (
    .a (opa),
    .b (opb),
    .g (rd_g),
    .p (rd_p)
  );

  rma_ks_prefix #(.W(W_RD)) u_ks_rd (
    .g_in (rd_g),
    .p_in (rd_p),
    .sum  (rd_sum)
  );

  // Bit N+1 of A + B + (2^(N+1) - m) is set exactly when A + B >= m.
  logic         wrap;
  logic [N-1:0] res_next;

  assign wrap     = rd_sum[N+1];
  assign res_next = wrap ? rd_sum[N-1:0] : pl_sum[N-1:0];

  // ---------------- output stage ----------------
  if (REG_OUT) begin : g_reg
    logic [N-1:0] res_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q <= '0;
      end else begin
        res_q <= res_next;
      end
    end

    assign res = res_q;
  end else begin : g_comb
    assign res = res_next;
  end

  // ---------------- checks ----------------
  logic         in_rng;
  logic [N:0]   ref_sum;

  assign in_rng  = ({1'b0, opa} < MOD_V) && ({1'b0, opb} < MOD_V);
  assign ref_sum = {1'b0, opa} + {1'b0, opb};

  // R1: no wrap below m, plain candidate passes unchanged
  p_low_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rng && (ref_sum < MOD_V)) |-> (!wrap && ({1'b0, res_next} == ref_sum)));

  // R1: plain candidate never exceeds N bits when it is the one chosen
  p_plain_fits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rng && !wrap) |-> (pl_sum[N+1:N] == 2'b00));

  // R2: at or above m, the reduced candidate is taken
  p_wrap_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rng && (ref_sum >= MOD_V)) |-> (wrap && ({1'b0, res_next} == (ref_sum - MOD_V))));

  // R2: the reduced candidate has the expected upper bits in either case
  p_reduced_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_rng |-> ((rd_sum[N+2] == 1'b0) && (!wrap || (rd_sum[N] == 1'b0))));

  // R4: the result stays inside the residue range
  p_below_mod_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_rng |-> ({1'b0, res_next} < MOD_V));

  if (REG_OUT) begin : g_reg_chk
    // R7: registered result is the modular sum of the previous cycle's operands
    p_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_rng |=> ({1'b0, res} == (($past(ref_sum) >= MOD_V) ?
                                  ($past(ref_sum) - MOD_V) : $past(ref_sum))));
  end

endmodule

// File: tb/test_rns_modadd_anticip.sv
`timescale 1ns/1ps
module test_rns_modadd_anticip;

  localparam int N = 16;
  localparam int unsigned MODS [3] = '{32'd49151, 32'd49152, 32'd57343};

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic         rst_n;
  logic [N-1:0] opa [3];
  logic [N-1:0] opb [3];
  logic [N-1:0] res [3];
  logic [N-1:0] res_reg;

  rns_modadd_anticip #(.N(N), .MOD_KIND(0), .REG_OUT(1'b0)) i_rns_modadd_anticip (
    .clk(clk), .rst_n(rst_n), .opa(opa[0]), .opb(opb[0]), .res(res[0]));
  rns_modadd_anticip #(.N(N), .MOD_KIND(1), .REG_OUT(1'b0)) i_rns_modadd_anticip_k1 (
    .clk(clk), .rst_n(rst_n), .opa(opa[1]), .opb(opb[1]), .res(res[1]));
  rns_modadd_anticip #(.N(N), .MOD_KIND(2), .REG_OUT(1'b0)) i_rns_modadd_anticip_k2 (
    .clk(clk), .rst_n(rst_n), .opa(opa[2]), .opb(opb[2]), .res(res[2]));
  rns_modadd_anticip #(.N(N), .MOD_KIND(2), .REG_OUT(1'b1)) i_rns_modadd_anticip_reg (
    .clk(clk), .rst_n(rst_n), .opa(opa[2]), .opb(opb[2]), .res(res_reg));

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  function automatic int unsigned ref_mod(input int unsigned a, input int unsigned b,
                                          input int unsigned m);
    return (a + b) % m;
  endfunction

  task automatic check(input string tag, input int kind, input int unsigned a,
                       input int unsigned b, input int unsigned got, input int unsigned exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s kind=%0d a=%0d b=%0d actual=%0d expected=%0d",
               tag, kind, a, b, got, exp);
    end
  endtask

  // Combinational instance: result checked 1 ns after the operands change.
  task automatic apply(input int k, input int unsigned a, input int unsigned b,
                       input string tag);
    int unsigned exp;
    @(negedge clk);
    opa[k] = N'(a);
    opb[k] = N'(b);
    #1;
    exp = ref_mod(a, b, MODS[k]);
    check(tag, k, a, b, int'(res[k]), exp);
    checks++;   // R4: range check on every result
    if (int'(res[k]) >= MODS[k]) begin
      failures++;
      $display("FAIL R4 kind=%0d a=%0d b=%0d actual=%0d expected=below %0d",
               k, a, b, res[k], MODS[k]);
    end
  endtask

  // Registered instance (kind 2): hold before the edge, new value after it.
  task automatic apply_reg(input int unsigned a, input int unsigned b);
    int unsigned old_exp;
    @(negedge clk);
    old_exp = ref_mod(int'(opa[2]), int'(opb[2]), MODS[2]);
    opa[2] = N'(a);
    opb[2] = N'(b);
    #1;
    check("R7 hold", 2, a, b, int'(res_reg), old_exp);
    @(negedge clk);
    check("R7 capture", 2, a, b, int'(res_reg), ref_mod(a, b, MODS[2]));
  endtask

  initial begin
    int unsigned seed_unused;
    rst_n = 1'b0;
    for (int k = 0; k < 3; k++) begin
      opa[k] = '0;
      opb[k] = '0;
    end
    seed_unused = $urandom(32'd4242);

    // R8: reset state
    repeat (3) @(negedge clk);
    check("R8 reset state", 2, 0, 0, int'(res_reg), 0);
    opa[2] = N'(100);
    opb[2] = N'(200);
    @(negedge clk);
    check("R8 held in reset", 2, 100, 200, int'(res_reg), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 first capture", 2, 100, 200, int'(res_reg), 300);

    for (int k = 0; k < 3; k++) begin
      int unsigned m;
      m = MODS[k];
      // R6: zero operands
      apply(k, 0, 0, "R6");
      apply(k, m - 1, 0, "R6");
      apply(k, 0, m - 1, "R6");
      apply(k, 12345, 0, "R6");
      // R3: modulus value, m-1 plus 1 wraps to zero, m-2 plus 1 does not
      apply(k, m - 1, 1, "R3");
      apply(k, m - 2, 1, "R3");
      // R5: boundary sums, both operand orders
      for (int s = 0; s < 4; s++) begin
        int unsigned sum;
        int unsigned x;
        case (s)
          0: sum = m - 1;
          1: sum = m;
          2: sum = m + 1;
          default: sum = 2 * m - 2;
        endcase
        x = (sum > m - 1) ? m - 1 : sum;
        apply(k, x, sum - x, "R5");
        apply(k, sum - x, x, "R5");
      end
      apply(k, m / 2, m / 2, "R7 same-cycle");
      // R1/R2: random residues
      for (int i = 0; i < 300; i++) begin
        int unsigned a;
        int unsigned b;
        a = $urandom % m;
        b = $urandom % m;
        apply(k, a, b, (a + b < m) ? "R1" : "R2");
      end
    end

    // R7: registered variant
    apply_reg(MODS[2] - 1, MODS[2] - 1);
    apply_reg(0, 0);
    for (int i = 0; i < 100; i++) begin
      apply_reg($urandom % MODS[2], $urandom % MODS[2]);
    end

    // R8: asynchronous clear between clock edges
    apply_reg(40000, 1000);
    @(negedge clk);
    #0.5;
    rst_n = 1'b0;
    #0.5;
    check("R8 async clear", 2, 40000, 1000, int'(res_reg), 0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule